// File: doc/BRIEF.md
# Two-Master Downstream Ownership Controller

This block chooses which of two upstream I2C masters, side 0 or side 1, is joined to one shared downstream bus. It also raises the interrupts that go with each change of owner. Each side writes three control bits as one transaction:

- an ownership bit,
- a link bit,
- a recovery-request bit.

The write is held as pending and is applied only when that side's upstream STOP is reported. There is no arbitration. Either side may take the downstream bus at any time, even while the other side is using it.

When ownership or the link changes, the block works out the effects:

- The side that was connected is flagged as having lost the bus.
- If the applying transaction asked for it, the downstream bus is kept isolated while an external recovery sequencer runs. The new owner is then connected and told that the initialisation is done.
- With no recovery requested, the new owner is connected at once. It is flagged only if the downstream monitor reports the bus as not idle at that moment.

Each side has three sticky status bits, three mask bits and an active-low interrupt. The I2C decoding, the pass switches and the recovery waveform are outside the block. They appear here only as strobes, a select, and a start/done handshake.

Top module: `msel_top`

## Requirements
- R1: After reset, sel_en, rec_start, both status vectors, req_q and conn_q are all 0, and int_n is 2'b11.
- R2: A control write from side i is applied only on a stop_up[i] pulse that follows it. A STOP from the other side, or a STOP with no pending write, changes nothing.
- R3: The downstream bus is linked when conn_q[0] differs from conn_q[1]. The owner, given on sel_owner, is side 1 when req_q[0] differs from req_q[1], and side 0 otherwise. req_q and conn_q show the applied bits of both sides to both masters.
- R4: Takeover needs no arbitration. When a side takes a linked bus from the other side, the previous owner's status bit 0 (lost) is set.
- R5: When the applied bits call for no link, sel_en drops whatever the ownership bits are. A previously connected owner gets status bit 0 set.
- R6: If a switch to a new owner is applied by a transaction whose init bit is 1, the following happens in order:
  - sel_en goes to 0 and rec_start goes to 1.
  - Both hold until a rec_done pulse.
  - On that pulse, the new owner is connected and its status bit 1 (init done) is set.
- R7: While rec_start is high, STOP pulses do not apply pending writes. The write stays pending for a later STOP from the same side.
- R8: A switch made without recovery sets the new owner's status bit 2 (busy at switch) only if ds_busy is 1 in the applying cycle. If ds_busy is 0, no status bit is set for the new owner.
- R9: Status bits stay set until stat_rd[i] clears side i's bits. A set arriving in the same cycle as the clear wins.
- R10: int_n[i] is low exactly when side i has a status bit set whose mask bit is 0. Side i's masks are msk_val[3i+2:3i], loaded on msk_wr[i], and use the same bit order as the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 2 | Per-side control write strobe |
| ctl_req | input | 2 | Per-side ownership bit to write |
| ctl_conn | input | 2 | Per-side link bit to write |
| ctl_init | input | 2 | Per-side recovery-request bit to write |
| stop_up | input | 2 | Per-side upstream STOP seen |
| msk_wr | input | 2 | Per-side mask write strobe |
| msk_val | input | 6 | Mask values, side i in bits [3i+2:3i] |
| stat_rd | input | 2 | Per-side status read (clears that side) |
| ds_busy | input | 1 | Downstream monitor: bus not idle |
| rec_done | input | 1 | Recovery sequencer finished (pulse) |
| rec_start | output | 1 | Recovery requested, held until done |
| sel_en | output | 1 | Downstream link enabled |
| sel_owner | output | 1 | Side connected when sel_en is 1 |
| req_q | output | 2 | Applied ownership bits of both sides |
| conn_q | output | 2 | Applied link bits of both sides |
| stat0 | output | 3 | Side 0 status {busy, init, lost} |
| stat1 | output | 3 | Side 1 status {busy, init, lost} |
| int_n | output | 2 | Per-side active-low interrupt |

## Verification
The ownership logic is driven through five patterns:

- **First link from an empty bus.** Checks the deferred apply, and that STOPs from the other side or with nothing pending are ignored.
- **Takeover onto a busy downstream bus.** Separates the lost flag from the busy flag and shows they land on different sides.
- **Takeover with recovery requested.** A STOP from the other side is placed inside the recovery window, which tells held commits from applied ones. The link is then dropped under a mask, which separates status from interrupt.
- **Join onto an idle bus.** Must raise nothing.
- **Takeover whose lost flag coincides with a status read.** Exposes any ordering fault between set and clear.

// File: rtl/msel_pkg.sv
package msel_pkg;
  localparam int NSIDE = 2;
  localparam int ST_W  = 3;
  localparam int ST_LOST = 0;
  localparam int ST_INIT = 1;
  localparam int ST_BUSY = 2;

  typedef enum logic {PH_RUN, PH_RECOV} phase_t;

  // link exists when the two link bits disagree
  function automatic logic link_of(input logic [NSIDE-1:0] c);
    return c[0] ^ c[1];
  endfunction

  // side 1 owns when the ownership bits disagree, side 0 otherwise
  function automatic logic owner_of(input logic [NSIDE-1:0] r);
    return r[0] ^ r[1];
  endfunction
endpackage

// File: rtl/msel_ctl_bank.sv
module msel_ctl_bank (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic req_i,
  input  logic conn_i,
  input  logic init_i,
  input  logic stop_i,
  input  logic hold_i,
  output logic commit_o,
  output logic cinit_o,
  output logic nx_req_o,
  output logic nx_conn_o,
  output logic q_req_o,
  output logic q_conn_o
);
  logic pend_v, pend_req, pend_conn, pend_init;

  assign commit_o  = stop_i && pend_v && !hold_i;
  assign cinit_o   = commit_o && pend_init;
  assign nx_req_o  = commit_o ? pend_req  : q_req_o;
  assign nx_conn_o = commit_o ? pend_conn : q_conn_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_req  <= 1'b0;
      pend_conn <= 1'b0;
      pend_init <= 1'b0;
      q_req_o   <= 1'b0;
      q_conn_o  <= 1'b0;
    end else begin
      if (commit_o) begin
        q_req_o  <= pend_req;
        q_conn_o <= pend_conn;
        pend_v   <= 1'b0;
      end
      if (wr_i) begin
        pend_v    <= 1'b1;
        pend_req  <= req_i;
        pend_conn <= conn_i;
        pend_init <= init_i;
      end
    end
  end

  AST_DEFER_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_i && pend_v) |=> ($stable(q_req_o) && $stable(q_conn_o))); // R2
endmodule

// File: rtl/msel_switch_fsm.sv
module msel_switch_fsm
  import msel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSIDE-1:0] commit_i,
  input  logic [NSIDE-1:0] cinit_i,
  input  logic [NSIDE-1:0] nx_req_i,
  input  logic [NSIDE-1:0] nx_conn_i,
  input  logic             ds_busy_i,
  input  logic             rec_done_i,
  output logic             hold_o,
  output logic             rec_start_o,
  output logic             sel_en_o,
  output logic             sel_owner_o,
  output logic [NSIDE-1:0] lost_ev_o,
  output logic [NSIDE-1:0] init_ev_o,
  output logic [NSIDE-1:0] busy_ev_o
);
  phase_t phase;
  logic   tgt_own;
  logic   any_commit, want_init, new_en, new_own, drop, join_w, done_w;

  assign any_commit = |commit_i;
  assign want_init  = |cinit_i;
  assign new_en     = link_of(nx_conn_i);
  assign new_own    = owner_of(nx_req_i);
  assign drop   = (phase == PH_RUN) && any_commit && sel_en_o &&
                  (!new_en || (new_own != sel_owner_o));
  assign join_w = (phase == PH_RUN) && any_commit && new_en &&
                  (!sel_en_o || (new_own != sel_owner_o));
  assign done_w = (phase == PH_RECOV) && rec_done_i;

  assign hold_o      = (phase == PH_RECOV);
  assign rec_start_o = (phase == PH_RECOV);

  always_comb begin
    lost_ev_o = '0;
    init_ev_o = '0;
    busy_ev_o = '0;
    for (int s = 0; s < NSIDE; s++) begin
      lost_ev_o[s] = drop   && (sel_owner_o == s[0]);
      busy_ev_o[s] = join_w && !want_init && ds_busy_i && (new_own == s[0]);
      init_ev_o[s] = done_w && (tgt_own == s[0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_RUN;
      tgt_own     <= 1'b0;
      sel_en_o    <= 1'b0;
      sel_owner_o <= 1'b0;
    end else if (done_w) begin
      phase       <= PH_RUN;
      sel_en_o    <= 1'b1;
      sel_owner_o <= tgt_own;
    end else if (join_w && want_init) begin
      phase    <= PH_RECOV;
      tgt_own  <= new_own;
      sel_en_o <= 1'b0;
    end else if (join_w) begin
      sel_en_o    <= 1'b1;
      sel_owner_o <= new_own;
    end else if (drop) begin
      sel_en_o <= 1'b0;
    end
  end

  AST_REC_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    rec_start_o |-> !sel_en_o); // R6
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> (commit_i == '0)); // R7
  AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_commit && !rec_done_i) |=> ($stable(sel_en_o) && $stable(sel_owner_o))); // R2
  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lost_ev_o)); // R4
endmodule

// File: rtl/msel_irq_unit.sv
module msel_irq_unit
  import msel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_i,
  input  logic            rd_i,
  input  logic            msk_wr_i,
  input  logic [ST_W-1:0] msk_i,
  output logic [ST_W-1:0] stat_o,
  output logic            int_n_o
);
  logic [ST_W-1:0] msk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_o <= '0;
      msk_q  <= '0;
    end else begin
      stat_o <= (rd_i ? '0 : stat_o) | set_i;
      if (msk_wr_i) msk_q <= msk_i;
    end
  end

  assign int_n_o = ~|(stat_o & ~msk_q);

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i))); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (set_i == '0)) |=> (stat_o == '0)); // R9
endmodule

// File: rtl/msel_top.sv
module msel_top
  import msel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ctl_wr,
  input  logic [1:0] ctl_req,
  input  logic [1:0] ctl_conn,
  input  logic [1:0] ctl_init,
  input  logic [1:0] stop_up,
  input  logic [1:0] msk_wr,
  input  logic [5:0] msk_val,
  input  logic [1:0] stat_rd,
  input  logic       ds_busy,
  input  logic       rec_done,
  output logic       rec_start,
  output logic       sel_en,
  output logic       sel_owner,
  output logic [1:0] req_q,
  output logic [1:0] conn_q,
  output logic [2:0] stat0,
  output logic [2:0] stat1,
  output logic [1:0] int_n
);
  logic [NSIDE-1:0] commit_w, cinit_w, nx_req_w, nx_conn_w;
  logic [NSIDE-1:0] lost_ev, init_ev, busy_ev;
  logic             hold_w;
  logic [ST_W-1:0]  stat_w [NSIDE];

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    msel_ctl_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_i(ctl_wr[g]), .req_i(ctl_req[g]), .conn_i(ctl_conn[g]),
      .init_i(ctl_init[g]), .stop_i(stop_up[g]), .hold_i(hold_w),
      .commit_o(commit_w[g]), .cinit_o(cinit_w[g]),
      .nx_req_o(nx_req_w[g]), .nx_conn_o(nx_conn_w[g]),
      .q_req_o(req_q[g]), .q_conn_o(conn_q[g])
    );

    logic [ST_W-1:0] set_w;
    always_comb begin
      set_w          = '0;
      set_w[ST_LOST] = lost_ev[g];
      set_w[ST_INIT] = init_ev[g];
      set_w[ST_BUSY] = busy_ev[g];
    end

    msel_irq_unit u_irq (
      .clk(clk), .rst_n(rst_n), .set_i(set_w), .rd_i(stat_rd[g]),
      .msk_wr_i(msk_wr[g]), .msk_i(msk_val[ST_W*g +: ST_W]),
      .stat_o(stat_w[g]), .int_n_o(int_n[g])
    );
  end

  msel_switch_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .commit_i(commit_w), .cinit_i(cinit_w),
    .nx_req_i(nx_req_w), .nx_conn_i(nx_conn_w),
    .ds_busy_i(ds_busy), .rec_done_i(rec_done),
    .hold_o(hold_w), .rec_start_o(rec_start),
    .sel_en_o(sel_en), .sel_owner_o(sel_owner),
    .lost_ev_o(lost_ev), .init_ev_o(init_ev), .busy_ev_o(busy_ev)
  );

  assign stat0 = stat_w[0];
  assign stat1 = stat_w[1];
endmodule

// File: tb/tb_msel_top.sv
module tb_msel_top;
  localparam int CLK_PER = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ctl_wr = '0, ctl_req = '0, ctl_conn = '0, ctl_init = '0;
  logic [1:0] stop_up = '0, msk_wr = '0, stat_rd = '0;
  logic [5:0] msk_val = '0;
  logic ds_busy = 1'b0, rec_done = 1'b0;
  logic rec_start, sel_en, sel_owner;
  logic [1:0] req_q, conn_q, int_n;
  logic [2:0] stat0, stat1;
  int nvec = 0, nbad = 0;

  always #(CLK_PER/2) clk = ~clk;

  msel_top dut (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int s, logic r, logic c, logic i);
    ctl_wr[s] = 1'b1; ctl_req[s] = r; ctl_conn[s] = c; ctl_init[s] = i;
    tick();
    ctl_wr = '0;
  endtask

  task automatic stop(int s);
    stop_up[s] = 1'b1; tick(); stop_up = '0;
  endtask

  task automatic clear_all();
    stat_rd = 2'b11; tick(); stat_rd = '0;
  endtask

  task automatic t_reset();
    chk("R1 sel_en", 8'(sel_en), 8'd0);
    chk("R1 rec_start", 8'(rec_start), 8'd0);
    chk("R1 int_n", 8'(int_n), 8'h3);
    chk("R1 stat", {2'b0, stat1, stat0}, 8'h0);
    chk("R1 req_q/conn_q", {4'b0, req_q, conn_q}, 8'h0);
  endtask

  task automatic t_defer();
    stop(0);
    chk("R2 stop without write", {6'b0, sel_en, conn_q[0]}, 8'h0);
    wr(0, 1'b0, 1'b1, 1'b0);
    chk("R2 write held", {6'b0, sel_en, conn_q[0]}, 8'h0);
    stop(1);
    chk("R2 other side stop", {6'b0, sel_en, conn_q[0]}, 8'h0);
    stop(0);
    chk("R3 linked owner0", {5'b0, sel_en, sel_owner, conn_q[0]}, 8'b101);
    chk("R8 idle join no irq", {2'b0, stat1, stat0}, 8'h0);
  endtask

  task automatic t_takeover();
    ds_busy = 1'b1;
    wr(1, 1'b1, 1'b0, 1'b0);
    stop(1);
    ds_busy = 1'b0;
    chk("R4 owner1", {6'b0, sel_en, sel_owner}, 8'b11);
    chk("R3 peer view req_q", 8'(req_q), 8'b10);
    chk("R4 lost to side0", 8'(stat0), 8'b001);
    chk("R8 busy to side1", 8'(stat1), 8'b100);
    chk("R10 both irq", 8'(int_n), 8'b00);
    tick();
    chk("R9 sticky", {2'b0, stat1, stat0}, {2'b0, 3'b100, 3'b001});
    clear_all();
    chk("R9 read clears", {2'b0, stat1, stat0}, 8'h0);
    chk("R10 irq idle", 8'(int_n), 8'b11);
  endtask

  task automatic t_recovery();
    msk_val = 6'b000_001; msk_wr = 2'b01; tick(); msk_wr = '0;
    wr(0, 1'b1, 1'b1, 1'b1);
    stop(0);
    chk("R6 isolate", {6'b0, sel_en, rec_start}, 8'b01);
    chk("R4 lost side1", 8'(stat1), 8'b001);
    chk("R10 irq side1 only", 8'(int_n), 8'b01);
    wr(1, 1'b1, 1'b1, 1'b0);
    stop(1);
    chk("R7 held during recovery", {6'b0, conn_q}, 8'b01);
    chk("R7 still recovering", 8'(rec_start), 8'd1);
    rec_done = 1'b1; tick(); rec_done = 1'b0;
    chk("R6 connect owner0", {5'b0, sel_en, sel_owner, rec_start}, 8'b100);
    chk("R6 init flag side0", 8'(stat0), 8'b010);
    chk("R10 init irq side0", 8'(int_n[0]), 8'd0);
    clear_all();
    stop(1);
    chk("R5 drop on unlink", {5'b0, sel_en, conn_q}, 8'b011);
    chk("R5 lost side0", 8'(stat0), 8'b001);
    chk("R10 masked lost", 8'(int_n), 8'b11);
  endtask

  task automatic t_idle_join();
    clear_all();
    wr(1, 1'b0, 1'b0, 1'b0);
    stop(1);
    chk("R3 owner1 via diff", {6'b0, sel_en, sel_owner}, 8'b11);
    chk("R8 idle no flags", {2'b0, stat1, stat0}, 8'h0);
    chk("R10 no irq", 8'(int_n), 8'b11);
  endtask

  task automatic t_setwins();
    wr(0, 1'b0, 1'b1, 1'b0);
    ds_busy = 1'b1; stat_rd = 2'b10; stop_up[0] = 1'b1;
    tick();
    stop_up = '0; stat_rd = '0; ds_busy = 1'b0;
    chk("R9 set beats read", 8'(stat1), 8'b001);
    chk("R8 busy side0", 8'(stat0), 8'b100);
    chk("R4 owner0 again", {6'b0, sel_en, sel_owner}, 8'b10);
  endtask

  initial begin
    #(CLK_PER * 100000);
    nbad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_defer();
    t_takeover();
    t_recovery();
    t_idle_join();
    t_setwins();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule